// File: doc/BRIEF.md
# Digital Mixer Frequency Drift Stabilizer

This block keeps a free-running oscillator on frequency without counting it over a gate window. The oscillator is divided by a power of two. Each time the divided clock completes a cycle, the current level of a reference square wave is captured in a single flip-flop, which acts as a digital mixer. When the oscillator is locked, the captured bit toggles slowly at about 50% duty. When the oscillator drifts, the pattern of edges in the mixer bit changes.

Each rising edge of the mixer bit fires an "up" pulse and each falling edge fires a "down" pulse. Each pulse lasts a programmable number of system clocks. While a pulse is active, a saturating correction accumulator moves by a programmable step on every clock. The accumulator stands in for an analog integrator. Its word drives an external tuning DAC or varicap.

The accumulator starts at mid-range. Two flags warn when the word comes close to either end of its range. An optional auto mode re-centres the word when a flag is raised. A watchdog flags a mixer that has stopped toggling. The oscillator, reference and manual re-centre request are all synchronized into the system clock domain.

Top module: `vfo_drift_stab`

## Requirements
- R1: After reset, corr_word equals the midpoint 2^(CORR_W-1) (128 for CORR_W=8), and up_strobe, down_strobe, near_high, near_low and mix_fault are all low.
- R2: Holding recenter_req high loads corr_word with the midpoint within four system clocks, whatever its previous value.
- R3: The mixer bit captures ref_in once every 2^DIV_STAGES rising edges of osc_in. A 0-to-1 change of the mixer bit fires one up pulse and a 1-to-0 change fires one down pulse. A capture that leaves the mixer bit unchanged fires no pulse and leaves corr_word unchanged.
- R4: An up pulse keeps up_strobe high for exactly up_len clocks, and a down pulse keeps down_strobe high for exactly dn_len clocks. A length of 0 produces no pulse and leaves corr_word unchanged.
- R5: On each clock with only up_strobe high, corr_word increases by step_size. On each clock with only down_strobe high, it decreases by step_size. With neither strobe high and no re-centre, it holds.
- R6: corr_word saturates at 0 and at 2^CORR_W-1 and never wraps.
- R7: near_high is high exactly when corr_word >= 2^CORR_W-1-M, and near_low is high exactly when corr_word <= M, where M = (2^CORR_W-1)/20 (integer division; 12 for CORR_W=8).
- R8: While autorecenter_en is high, a raised near flag reloads the midpoint on the next clock. While autorecenter_en is low, corr_word stays at its limit.
- R9: mix_fault rises once TIMEOUT clocks pass without a mixer edge, and it clears on the next mixer edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_in | input | 1 | Oscillator under control (asynchronous) |
| ref_in | input | 1 | Reference square wave (asynchronous) |
| recenter_req | input | 1 | Manual re-centre request, level sensitive |
| autorecenter_en | input | 1 | Re-centre automatically when a near flag is raised |
| up_len | input | LEN_W | Up pulse length in clocks |
| dn_len | input | LEN_W | Down pulse length in clocks |
| step_size | input | STEP_W | Accumulator change per active pulse clock |
| corr_word | output | CORR_W | Correction word sent to the tuning DAC |
| up_strobe | output | 1 | Up pulse active |
| down_strobe | output | 1 | Down pulse active |
| near_high | output | 1 | Correction is near its upper end |
| near_low | output | 1 | Correction is near its lower end |
| mix_fault | output | 1 | No mixer edge seen within TIMEOUT clocks |

## Verification
The mixer is driven with steady oscillator periods while the reference level is chosen in three ways. Repeating the same reference level must produce no pulse, which separates edge detection from level detection. Alternating the level must produce alternating up and down pulses. Random levels, lengths and steps check the accumulated word against a saturating model of the pulses. One-sided pulse lengths with large steps drive the word into each end of its range, which separates saturation from wrap-around and tests both near flags and auto re-centring. Stopping the oscillator tests the inactivity watchdog, and a final reference change must clear it.

// File: rtl/dstab_pkg.sv
package dstab_pkg;
  typedef enum logic [1:0] {
    OP_HOLD   = 2'd0,
    OP_RAISE  = 2'd1,
    OP_LOWER  = 2'd2,
    OP_CENTER = 2'd3
  } acc_op_e;
endpackage

// File: rtl/dstab_sync.sv
module dstab_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] meta_q;
  logic [WIDTH-1:0] stab_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d;
      stab_q <= meta_q;
    end
  end

  assign q = stab_q;
endmodule

// File: rtl/dstab_mixer.sv
module dstab_mixer #(
  parameter int DIV_STAGES = 15
) (
  input  logic clk,
  input  logic rst_n,
  input  logic osc_s,
  input  logic ref_s,
  output logic mix_rise,
  output logic mix_fall
);
  logic                  osc_d_q;
  logic [DIV_STAGES-1:0] div_q, div_nxt;
  logic                  mix_q, mix_nxt;
  logic                  osc_rise;
  logic                  sample;

  assign osc_rise = osc_s & ~osc_d_q;
  // the divided clock completes a cycle when the ripple count wraps
  assign sample   = osc_rise & (&div_q);

  always_comb begin
    div_nxt = div_q;
    mix_nxt = mix_q;
    if (osc_rise) div_nxt = div_q + 1'b1;
    if (sample)   mix_nxt = ref_s;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_d_q <= 1'b0;
      div_q   <= '0;
      mix_q   <= 1'b0;
    end else begin
      osc_d_q <= osc_s;
      div_q   <= div_nxt;
      mix_q   <= mix_nxt;
    end
  end

  assign mix_rise = sample &  ref_s & ~mix_q;
  assign mix_fall = sample & ~ref_s &  mix_q;
endmodule

// File: rtl/dstab_pulse.sv
module dstab_pulse #(
  parameter int LEN_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [LEN_W-1:0] len,
  output logic             active
);
  logic [LEN_W-1:0] cnt_q, cnt_nxt;

  always_comb begin
    cnt_nxt = cnt_q;
    if (trig)              cnt_nxt = len;
    else if (cnt_q != '0)  cnt_nxt = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_nxt;
  end

  assign active = (cnt_q != '0);
endmodule

// File: rtl/dstab_accum.sv
module dstab_accum
  import dstab_pkg::*;
#(
  parameter int W      = 12,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              raise,
  input  logic              lower,
  input  logic              reload,
  input  logic [STEP_W-1:0] step,
  output logic [W-1:0]      acc,
  output logic              near_hi,
  output logic              near_lo
);
  localparam int unsigned  FULL   = (1 << W) - 1;
  localparam int unsigned  MARGIN = FULL / 20;
  localparam logic [W-1:0] MID    = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] LO_TH  = W'(MARGIN);
  localparam logic [W-1:0] HI_TH  = W'(FULL - MARGIN);

  acc_op_e      op;
  logic [W:0]   step_x, sum, diff;
  logic [W-1:0] acc_q, acc_nxt;

  always_comb begin
    op = OP_HOLD;
    if (reload)              op = OP_CENTER;
    else if (raise && !lower) op = OP_RAISE;
    else if (lower && !raise) op = OP_LOWER;
  end

  assign step_x = {{(W+1-STEP_W){1'b0}}, step};
  assign sum    = {1'b0, acc_q} + step_x;
  assign diff   = {1'b0, acc_q} - step_x;

  always_comb begin
    case (op)
      OP_CENTER: acc_nxt = MID;
      OP_RAISE:  acc_nxt = sum[W]  ? '1 : sum[W-1:0];
      OP_LOWER:  acc_nxt = diff[W] ? '0 : diff[W-1:0];
      default:   acc_nxt = acc_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= MID;
    else        acc_q <= acc_nxt;
  end

  assign acc     = acc_q;
  assign near_hi = (acc_q >= HI_TH);
  assign near_lo = (acc_q <= LO_TH);
endmodule

// File: rtl/vfo_drift_stab.sv
module vfo_drift_stab #(
  parameter int CORR_W     = 12,
  parameter int STEP_W     = 8,
  parameter int LEN_W      = 8,
  parameter int DIV_STAGES = 15,
  parameter int TIMEOUT    = 4194304
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              osc_in,
  input  logic              ref_in,
  input  logic              recenter_req,
  input  logic              autorecenter_en,
  input  logic [LEN_W-1:0]  up_len,
  input  logic [LEN_W-1:0]  dn_len,
  input  logic [STEP_W-1:0] step_size,
  output logic [CORR_W-1:0] corr_word,
  output logic              up_strobe,
  output logic              down_strobe,
  output logic              near_high,
  output logic              near_low,
  output logic              mix_fault
);
  localparam int IDLE_W = $clog2(TIMEOUT + 1);
  localparam logic [IDLE_W-1:0] IDLE_LIM = IDLE_W'(TIMEOUT);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rst_pipe_q;
  logic       rst_core_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  logic [2:0] sync_q;
  logic       osc_s, ref_s, recenter_s;
  dstab_sync #(.WIDTH(3)) u_sync (
    .clk  (clk),
    .rst_n(rst_core_n),
    .d    ({osc_in, ref_in, recenter_req}),
    .q    (sync_q)
  );
  assign {osc_s, ref_s, recenter_s} = sync_q;

  logic mix_rise, mix_fall;
  dstab_mixer #(.DIV_STAGES(DIV_STAGES)) u_mixer (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .osc_s   (osc_s),
    .ref_s   (ref_s),
    .mix_rise(mix_rise),
    .mix_fall(mix_fall)
  );

  // index 0 acts upward, index 1 downward
  logic             trig   [2];
  logic [LEN_W-1:0] plen   [2];
  logic             active [2];
  assign trig[0] = mix_rise;
  assign trig[1] = mix_fall;
  assign plen[0] = up_len;
  assign plen[1] = dn_len;

  for (genvar k = 0; k < 2; k++) begin : g_pulse
    dstab_pulse #(.LEN_W(LEN_W)) u_pulse (
      .clk   (clk),
      .rst_n (rst_core_n),
      .trig  (trig[k]),
      .len   (plen[k]),
      .active(active[k])
    );
  end

  logic reload;
  assign reload = recenter_s | (autorecenter_en & (near_high | near_low));

  dstab_accum #(.W(CORR_W), .STEP_W(STEP_W)) u_accum (
    .clk    (clk),
    .rst_n  (rst_core_n),
    .raise  (active[0]),
    .lower  (active[1]),
    .reload (reload),
    .step   (step_size),
    .acc    (corr_word),
    .near_hi(near_high),
    .near_lo(near_low)
  );

  // mixer inactivity watchdog
  logic [IDLE_W-1:0] idle_q, idle_nxt;
  always_comb begin
    idle_nxt = idle_q;
    if (mix_rise || mix_fall)  idle_nxt = '0;
    else if (idle_q != IDLE_LIM) idle_nxt = idle_q + 1'b1;
  end
  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) idle_q <= '0;
    else             idle_q <= idle_nxt;
  end

  assign mix_fault   = (idle_q == IDLE_LIM);
  assign up_strobe   = active[0];
  assign down_strobe = active[1];
endmodule

// File: rtl/dstab_checker.sv
module dstab_checker #(
  parameter int W = 12
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] corr_word,
  input logic         up_strobe,
  input logic         down_strobe,
  input logic         near_high,
  input logic         near_low,
  input logic         autorecenter_en,
  input logic         reload
);
  localparam logic [W-1:0] MID = {1'b1, {(W-1){1'b0}}};

  assert_midpoint_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (corr_word == MID));

  assert_no_wrap_up_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (up_strobe && !down_strobe && !reload) |=> (corr_word >= $past(corr_word)));

  assert_no_wrap_down_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (down_strobe && !up_strobe && !reload) |=> (corr_word <= $past(corr_word)));

  assert_idle_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!up_strobe && !down_strobe && !reload) |=> $stable(corr_word));

  assert_auto_recenter_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (autorecenter_en && (near_high || near_low)) |=> (corr_word == MID));
endmodule

bind vfo_drift_stab dstab_checker #(.W(CORR_W)) u_dstab_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .corr_word      (corr_word),
  .up_strobe      (up_strobe),
  .down_strobe    (down_strobe),
  .near_high      (near_high),
  .near_low       (near_low),
  .autorecenter_en(autorecenter_en),
  .reload         (reload)
);

// File: tb/tb_vfo_drift_stab.sv
module tb_vfo_drift_stab;
  localparam int CLK_PERIOD = 10;
  localparam int CW   = 8;
  localparam int SW   = 8;
  localparam int LW   = 4;
  localparam int DIVS = 3;
  localparam int TMO  = 2000;
  localparam int MAXV = 255;
  localparam int MID  = 128;
  localparam int MARG = 12;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          osc_in = 1'b0, ref_in = 1'b0, recenter_req = 1'b0, autorecenter_en = 1'b0;
  logic [LW-1:0] up_len = '0, dn_len = '0;
  logic [SW-1:0] step_size = '0;
  logic [CW-1:0] corr_word;
  logic          up_strobe, down_strobe, near_high, near_low, mix_fault;

  vfo_drift_stab #(.CORR_W(CW), .STEP_W(SW), .LEN_W(LW), .DIV_STAGES(DIVS), .TIMEOUT(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .osc_in(osc_in), .ref_in(ref_in),
    .recenter_req(recenter_req), .autorecenter_en(autorecenter_en),
    .up_len(up_len), .dn_len(dn_len), .step_size(step_size),
    .corr_word(corr_word), .up_strobe(up_strobe), .down_strobe(down_strobe),
    .near_high(near_high), .near_low(near_low), .mix_fault(mix_fault));

  always #(CLK_PERIOD/2) clk = ~clk;

  int n_chk = 0, n_bad = 0;
  int exp_corr = MID;
  bit mix_exp = 1'b0;
  int exp_up = 0, exp_dn = 0;
  int up_cnt = 0, dn_cnt = 0, up_run = 0, dn_run = 0, last_up_w = 0, last_dn_w = 0;
  bit done = 1'b0;

  always @(negedge clk) begin
    if (up_strobe) up_run++;
    else if (up_run > 0) begin last_up_w = up_run; up_cnt++; up_run = 0; end
    if (down_strobe) dn_run++;
    else if (dn_run > 0) begin last_dn_w = dn_run; dn_cnt++; dn_run = 0; end
  end

  task automatic chk(string req, int act, int expv);
    n_chk++;
    if (act != expv) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic bit is_near(int v);
    return (v >= MAXV - MARG) || (v <= MARG);
  endfunction

  function automatic int model_pulse(int v, bit up, int len, int stp, bit au);
    for (int i = 0; i < len; i++) begin
      if (au && is_near(v)) v = MID;
      else if (up) v = (v + stp > MAXV) ? MAXV : v + stp;
      else         v = (v - stp < 0) ? 0 : v - stp;
    end
    if (au && is_near(v)) v = MID;
    return v;
  endfunction

  task automatic osc_run(int periods);
    for (int p = 0; p < periods; p++) begin
      osc_in = 1'b1; repeat (2) @(negedge clk);
      osc_in = 1'b0; repeat (2) @(negedge clk);
    end
  endtask

  task automatic run_ref(bit v, int periods);
    bit edge_seen;
    edge_seen = (v != mix_exp);
    ref_in = v;
    osc_run(periods);
    repeat (20) @(negedge clk);
    #1;
    if (edge_seen) begin
      mix_exp = v;
      if (v) begin
        if (up_len != 0) exp_up++;
        exp_corr = model_pulse(exp_corr, 1'b1, int'(up_len), int'(step_size), autorecenter_en);
      end else begin
        if (dn_len != 0) exp_dn++;
        exp_corr = model_pulse(exp_corr, 1'b0, int'(dn_len), int'(step_size), autorecenter_en);
      end
    end
  endtask

  task automatic chk_flags(string req);
    chk(req, int'(near_high), int'(exp_corr >= MAXV - MARG));
    chk(req, int'(near_low),  int'(exp_corr <= MARG));
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;
    // R1: reset state
    chk("R1 corr", int'(corr_word), MID);
    chk("R1 up", int'(up_strobe), 0);
    chk("R1 dn", int'(down_strobe), 0);
    chk("R1 hi", int'(near_high), 0);
    chk("R1 lo", int'(near_low), 0);
    chk("R1 fault", int'(mix_fault), 0);

    // R3 R4 R5: directed up then down
    up_len = 4'd4; dn_len = 4'd4; step_size = 8'd3;
    run_ref(1'b1, 12);
    chk("R5 up step", int'(corr_word), 140);
    chk("R4 up width", last_up_w, 4);
    run_ref(1'b0, 12);
    chk("R5 down step", int'(corr_word), 128);
    chk("R4 down width", last_dn_w, 4);
    run_ref(1'b0, 14);
    chk("R3 no edge corr", int'(corr_word), exp_corr);
    chk("R3 no edge pulses", dn_cnt, exp_dn);

    // R4: zero length
    up_len = 4'd0;
    run_ref(1'b1, 12);
    chk("R4 zero len corr", int'(corr_word), 128);
    chk("R4 zero len pulses", up_cnt, exp_up);
    run_ref(1'b0, 12);
    chk("R3 down corr", int'(corr_word), 116);

    // R5 R7: random patterns
    for (int it = 0; it < 40; it++) begin
      up_len    = LW'($urandom_range(0, 15));
      dn_len    = LW'($urandom_range(0, 15));
      step_size = SW'($urandom_range(0, 20));
      run_ref(1'($urandom_range(0, 1)), $urandom_range(12, 20));
      chk("R5 random corr", int'(corr_word), exp_corr);
      chk_flags("R7 random flags");
    end
    chk("R3 up count", up_cnt, exp_up);
    chk("R3 down count", dn_cnt, exp_dn);

    // R6 R7: saturate high
    up_len = 4'd15; dn_len = 4'd0; step_size = 8'd40;
    for (int t = 0; t < 8; t++) run_ref(~mix_exp, 12);
    chk("R6 sat high", int'(corr_word), MAXV);
    chk("R6 sat high model", exp_corr, MAXV);
    chk_flags("R7 high flags");

    // R8: auto off keeps limit, auto on recentres
    repeat (5) @(negedge clk); #1;
    chk("R8 auto off", int'(corr_word), MAXV);
    autorecenter_en = 1'b1;
    repeat (2) @(negedge clk); #1;
    chk("R8 auto on", int'(corr_word), MID);
    exp_corr = MID;
    autorecenter_en = 1'b0;

    // R6 R7: saturate low
    up_len = 4'd0; dn_len = 4'd15;
    for (int t = 0; t < 8; t++) run_ref(~mix_exp, 12);
    chk("R6 sat low", int'(corr_word), 0);
    chk_flags("R7 low flags");

    // R2: manual recentre
    recenter_req = 1'b1;
    repeat (4) @(negedge clk); #1;
    chk("R2 recenter", int'(corr_word), MID);
    recenter_req = 1'b0;
    exp_corr = MID;
    repeat (3) @(negedge clk);

    // R9: watchdog
    repeat (TMO + 100) @(negedge clk); #1;
    chk("R9 fault set", int'(mix_fault), 1);
    run_ref(~mix_exp, 12);
    chk("R9 fault clear", int'(mix_fault), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule